// File: doc/BRIEF.md
# Oscillator Tank Band-Search Controller

This block chooses which of eight oscillator tanks drives the first local oscillator of a dual-conversion tuner. Tank codes run from 0 (lowest frequency band) to 7 (highest). After a start pulse the controller programs a chosen first tank and waits a programmable number of clock cycles for the loop to settle. It then reads two status flags from the synthesizer: a lock flag and a one-bit tune-range flag that asks for a higher or a lower band. From these it either finishes or moves one tank up or down, programs the new tank and settles again.

Each programming step produces one control byte and a one-cycle write strobe. The top three bits of the byte hold the tank code, bit 4 is driven low, bits 3:2 carry the first loop's charge-pump current code and bits 1:0 carry the second loop's. The two current codes (0..3 select 0.2 mA to 0.8 mA in 0.2 mA steps) are copied from input pins on every write. The search ends with `done` when lock is seen, or with `fail` when the ladder runs out or the flag asks to go back to a tank already tried.

Top module: `tank_search`

## Requirements
- R1: After reset the tank code is 0, `busy_o`, `done_o`, `fail_o` and `ctrl_wr_o` are low.
- R2: A start pulse in idle loads `start_tank_i` as the tank code, raises `busy_o` and issues a write of that tank on the next cycle.
- R3: Every write strobe carries `ctrl_byte_o` = {tank code in bits 7:5, 0 in bit 4, `cp1_i` in bits 3:2, `cp2_i` in bits 1:0}.
- R4: Each tank visit lasts exactly `settle_i`+3 busy cycles (write, `settle_i`+1 settle cycles, one sample cycle); status is read only in the sample cycle.
- R5: A sampled lock of 1 ends the search with `done_o`=1 and the tank unchanged, whatever the tune-range flag says.
- R6: With lock 0 and `over_i`=0 the next tank is the current code minus one.
- R7: With lock 0 and `over_i`=1 the next tank is the current code plus one.
- R8: A step that would go below 0 or above 7 ends the search with `fail_o`=1 and the tank unchanged.
- R9: A step onto a tank already visited in this search ends it with `fail_o`=1 and the tank unchanged.
- R10: A start pulse while `busy_o` is high is ignored, including one in the final sample cycle.
- R11: `done_o` and `fail_o` are never high together, stay held in idle, and both clear when the next search is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (accepted only when idle) |
| start_tank_i | input | 3 | First tank code to try |
| settle_i | input | 16 | Settle wait in cycles after each write |
| cp1_i | input | 2 | First loop charge-pump current code |
| cp2_i | input | 2 | Second loop charge-pump current code |
| lock_i | input | 1 | Synthesizer lock flag |
| over_i | input | 1 | 1 asks for a higher tank, 0 for a lower one |
| ctrl_wr_o | output | 1 | One-cycle strobe for the control byte |
| ctrl_byte_o | output | 8 | Control byte to program |
| tank_o | output | 3 | Current tank code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search ended in lock |
| fail_o | output | 1 | Search ended without lock |

## Verification
The end of a search and the arrival of a new start request can share a single cycle: the sample cycle that sees lock is still a busy cycle, so a start pulse there must be dropped. The bench places the pulse exactly on that cycle, counted from the settle value, and judges that the next cycle shows idle with `done_o` held and the tank unchanged, with no further write strobe. A second start pulse mid-settle, carrying a different first tank, must leave the visit count and final tank of the running search intact.

// File: rtl/tank_search_pkg.sv
package tank_search_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_SAMPLE = 2'd3
  } search_state_t;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4: a load of a non-zero value must not report expiry next cycle
  a_r4_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !expired_o);
endmodule

// File: rtl/tank_step.sv
module tank_step #(
  parameter int TANK_W = 3,
  localparam int NTANK = 1 << TANK_W
) (
  input  logic [TANK_W-1:0] tank_i,
  input  logic              over_i,
  input  logic [NTANK-1:0]  visited_i,
  output logic [TANK_W-1:0] next_o,
  output logic              edge_o,
  output logic              revisit_o
);
  localparam logic [TANK_W-1:0] TOP = TANK_W'(NTANK - 1);

  always_comb begin
    if (over_i) begin
      edge_o = (tank_i == TOP);
      next_o = tank_i + 1'b1;
    end else begin
      edge_o = (tank_i == '0);
      next_o = tank_i - 1'b1;
    end
    revisit_o = visited_i[next_o];
  end
endmodule

// File: rtl/tank_search.sv
module tank_search
  import tank_search_pkg::*;
#(
  parameter int TANK_W   = 3,
  parameter int SETTLE_W = 16,
  parameter int CP_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [TANK_W-1:0]   start_tank_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CP_W-1:0]     cp1_i,
  input  logic [CP_W-1:0]     cp2_i,
  input  logic                lock_i,
  input  logic                over_i,
  output logic                ctrl_wr_o,
  output logic [TANK_W+2*CP_W:0] ctrl_byte_o,
  output logic [TANK_W-1:0]   tank_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o
);
  localparam int NTANK = 1 << TANK_W;

  search_state_t     state_q;
  logic [TANK_W-1:0] tank_q;
  logic [NTANK-1:0]  visited_q;
  logic              done_q, fail_q;
  logic              expired;
  logic [TANK_W-1:0] next_tank;
  logic              at_edge, revisit;

  settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (state_q == ST_WRITE),
    .load_val_i (settle_i),
    .expired_o  (expired)
  );

  tank_step #(.TANK_W(TANK_W)) u_step (
    .tank_i    (tank_q),
    .over_i    (over_i),
    .visited_i (visited_q),
    .next_o    (next_tank),
    .edge_o    (at_edge),
    .revisit_o (revisit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tank_q    <= '0;
      visited_q <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          tank_q    <= start_tank_i;
          visited_q <= '0;
          done_q    <= 1'b0;
          fail_q    <= 1'b0;
          state_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          visited_q <= visited_q | (NTANK'(1) << tank_q);
          state_q   <= ST_SETTLE;
        end
        ST_SETTLE: if (expired) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (lock_i) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (at_edge || revisit) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tank_q  <= next_tank;
            state_q <= ST_WRITE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_wr_o   = (state_q == ST_WRITE);
  assign ctrl_byte_o = {tank_q, 1'b0, cp1_i, cp2_i};
  assign tank_o      = tank_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;

  // R11: outcomes are exclusive
  a_r11_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  // R11: outcomes are cleared for the whole of a search
  a_r11_clear_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!done_o && !fail_o));
  // R6 / R7: tank moves by exactly one within a search
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && tank_o != $past(tank_o)) |->
      (tank_o == $past(tank_o) + 1 || tank_o == $past(tank_o) - 1));
  // R4: sampling is only reached through the settle wait
  a_r4_sample_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMPLE) |-> ($past(state_q) == ST_SETTLE && $past(expired)));
  // R3: written byte carries the current tank and a low spare bit
  a_r3_byte_layout: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |-> (ctrl_byte_o[TANK_W+2*CP_W -: TANK_W] == tank_o && !ctrl_byte_o[2*CP_W]));
  // R8 / R9: a failing end leaves the tank where it was
  a_r8_fail_holds_tank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> $stable(tank_o));
  // R10: no write strobe follows an idle cycle without a start
  a_r10_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !ctrl_wr_o);
endmodule

// File: tb/tb_tank_search.sv
module tb_tank_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  start_tank_i = '0;
  logic [15:0] settle_i = '0;
  logic [1:0]  cp1_i = '0, cp2_i = '0;
  logic        lock_i, over_i;
  logic        ctrl_wr_o, busy_o, done_o, fail_o;
  logic [7:0]  ctrl_byte_o;
  logic [2:0]  tank_o;

  int errors = 0;
  int checks = 0;
  int cur_tgt = 0;
  int cur_mode = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  tank_search dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_tank_i(start_tank_i),
    .settle_i(settle_i), .cp1_i(cp1_i), .cp2_i(cp2_i), .lock_i(lock_i),
    .over_i(over_i), .ctrl_wr_o(ctrl_wr_o), .ctrl_byte_o(ctrl_byte_o),
    .tank_o(tank_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  // Synthesizer model: mode 0 normal, 2 never locks, 3 reports over=1 at lock
  always_comb begin
    lock_i = (cur_mode != 2) && (int'(tank_o) == cur_tgt);
    over_i = (cur_mode == 3 && lock_i) ? 1'b1 : (int'(tank_o) < cur_tgt);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  localparam int NV = 8;
  localparam int V_START[NV] = '{3, 1, 6, 0, 4, 2, 7, 0};
  localparam int V_TGT  [NV] = '{3, 6, 2, 8, 0, 5, 4, 0};
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 2, 2, 3, 0};
  localparam int V_SET  [NV] = '{2, 0, 5, 1, 2, 3, 1, 7};
  localparam int E_TANK [NV] = '{3, 6, 2, 7, 0, 5, 4, 0};
  localparam int E_DONE [NV] = '{1, 1, 1, 0, 0, 0, 1, 1};
  localparam int E_VIS  [NV] = '{1, 6, 5, 8, 5, 4, 4, 1};

  int busy_cnt, wr_cnt, last_wr;

  // poke_at: busy-cycle index where a second start is raised (-1 = none)
  task automatic run(input int st, input int tgt, input int mode, input int stl,
                     input int cpv, input int poke_at);
    cur_tgt = tgt; cur_mode = mode;
    @(negedge clk);
    start_tank_i = 3'(st); settle_i = 16'(stl);
    cp1_i = 2'(cpv); cp2_i = ~2'(cpv);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    busy_cnt = 0; wr_cnt = 0; last_wr = -1;
    check("R2 busy after start", int'(busy_o), 1);
    check("R11 outcomes cleared", int'(done_o | fail_o), 0);
    while (busy_o && busy_cnt < 2000) begin
      if (ctrl_wr_o) begin
        wr_cnt++;
        if (wr_cnt == 1) check("R2 first tank", int'(tank_o), st);
        else check("R6 R7 one-step move", (int'(tank_o) - last_wr) * (int'(tank_o) - last_wr), 1);
        last_wr = int'(tank_o);
        check("R3 control byte", int'(ctrl_byte_o),
              int'({tank_o, 1'b0, 2'(cpv), ~2'(cpv)}));
      end
      if (busy_cnt == poke_at) begin
        start_i = 1'b1; start_tank_i = 3'(st ^ 5);
      end else start_i = 1'b0;
      busy_cnt++;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tank reset", int'(tank_o), 0);
    check("R1 flags reset", int'({busy_o, done_o, fail_o, ctrl_wr_o}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(V_START[i], V_TGT[i], V_MODE[i], V_SET[i], i & 3, -1);
      check("R5 R8 R9 final tank", int'(tank_o), E_TANK[i]);
      check("R5 done", int'(done_o), E_DONE[i]);
      check("R8 R9 fail", int'(fail_o), 1 - E_DONE[i]);
      check("R4 busy cycles", busy_cnt, E_VIS[i] * (V_SET[i] + 3));
      check("R6 R7 visits", wr_cnt, E_VIS[i]);
    end

    // R11: outcome and tank held in idle
    repeat (6) @(negedge clk);
    check("R11 done held", int'(done_o), 1);
    check("R11 tank held idle", int'(tank_o), 0);

    // R10: start mid-settle with another first tank is ignored
    run(1, 4, 0, 4, 2, 3);
    check("R10 tank after mid poke", int'(tank_o), 4);
    check("R10 visits after mid poke", wr_cnt, 4);
    check("R10 busy after mid poke", busy_cnt, 4 * 7);

    // R10: start in the very sample cycle that sees lock (index settle+2)
    run(3, 3, 0, 2, 1, 4);
    check("R10 idle after final-cycle poke", int'(busy_o), 0);
    check("R10 done after final-cycle poke", int'(done_o), 1);
    @(negedge clk);
    check("R10 no write after final-cycle poke", int'(ctrl_wr_o | busy_o), 0);
    check("R10 tank after final-cycle poke", int'(tank_o), 3);

    // R9 via fail then R11 clearing on a new accepted search
    run(2, 5, 2, 0, 0, -1);
    check("R9 reversal fail", int'(fail_o), 1);
    run(5, 5, 0, 0, 3, -1);
    check("R11 fail cleared by new search", int'(fail_o), 0);
    check("R5 lock done", int'(done_o), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule